// File: doc/BRIEF.md
# Read-While-Write Bank Arbiter

This block sits between the bus read port of a multi-bank serial flash controller and the serial shifter that drives the memory pins. When one bank is in a program cycle, the block keeps re-issuing status-read commands to it until the device reports that it is no longer busy. Bus reads that arrive during this period are handled in one of two ways. A read aimed at the bank that is programming waits, and the bus stays not-ready, until programming ends. A read aimed at any other bank is slotted in between two status reads, and polling then picks up again on the programming bank.

Only one bank can be programming at a time. Its index is held in a register, loaded by a start pulse from the write path. Commands never overlap: a new command is offered to the shifter only after the previous transaction has completed. Every bank select drops for at least one cycle between transactions, so each command begins with a fresh chip-select assertion. When no bank is programming, reads go straight to the shifter with no extra wait.

Top module: `flash_rww_arbiter`

## Requirements
- R1: With no bank programming, a read request is offered to the shifter as opcode 8'h03 on the clock after `rd_req` is first seen, with `bank_sel` one-hot at bit `rd_bank`. `rd_ready` is high for exactly one cycle, the cycle after `xfer_done`.
- R2: A `prog_start` pulse while `prog_busy` is 0 loads `prog_bank` into `prog_idx` and raises `prog_busy`. A `prog_start` while `prog_busy` is 1 has no effect on `prog_idx`.
- R3: While `prog_busy` is 1 and no read is being served, the block issues status-read commands (opcode 8'h05) to bank `prog_idx` one after another.
- R4: Bit 0 of the status byte returned on `xfer_rx` with `xfer_done` decides completion. A 0 in that bit clears `prog_busy` on the next clock, whatever the other seven bits hold. A 1 in that bit keeps polling going.
- R5: A read to bank `prog_idx` while `prog_busy` is 1 gets no `rd_ready` until `prog_busy` has gone to 0. Once that happens, the read is served.
- R6: A read to any other bank while `prog_busy` is 1 is served while programming continues. The command just before it and the command just after it are status reads to the programming bank.
- R7: `bank_sel` is all zeros for at least one cycle between the end of one transaction (`xfer_done`) and the acceptance of the next command.
- R8: No command is offered while a transaction is in flight (accepted and not yet done), so polling is only ever interrupted between status transactions.
- R9: At most one bit of `bank_sel` is high in any cycle.
- R10: After reset, `bank_sel`, `cmd_valid`, `rd_ready` and `prog_busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Pulse from the write path: a bank has entered its program cycle |
| prog_bank | input | BANK_W | Bank index that accompanies `prog_start` |
| rd_req | input | 1 | Bus read request, held until `rd_ready` |
| rd_bank | input | BANK_W | Target bank of the read, stable while `rd_req` is high |
| rd_ready | output | 1 | One-cycle completion of the bus read |
| bank_sel | output | NUM_BANKS | Per-bank select toward the shifter, active high |
| cmd_valid | output | 1 | Command offered to the shifter |
| cmd_opcode | output | 8 | Opcode of the offered command |
| cmd_ready | input | 1 | Shifter accepts the command this cycle |
| xfer_done | input | 1 | Shifter finished the current transaction |
| xfer_rx | input | 8 | Byte returned by the shifter with `xfer_done` |
| prog_busy | output | 1 | A bank is programming |
| prog_idx | output | BANK_W | Index of the programming bank |

## Verification
The main function is exercised under five input patterns. The first is a read to an idle array, which pins down the base latency that no polling may extend. The second is a program cycle with no reads, which shows the poll count is set by bit 0 alone, since the status bytes carry noise in the other bits. The third is a read to the programming bank, which must wait for the final poll. The fourth is a read to a different bank, which must land between two polls and complete while programming is still underway. The fifth is a second start pulse during programming, which must leave the stored index untouched. A shifter model in the bench watches every command for overlap with an open transaction and for a missing deselect cycle, which separates correct preemption from preemption in the middle of a transaction.

// File: rtl/rww_pkg.sv
package rww_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL_ISSUE,
    ST_POLL_WAIT,
    ST_POLL_GAP,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_RD_ACK
  } rww_state_e;

  // Busy flag extracted from a returned status byte.
  function automatic logic status_busy(input logic [7:0] sbyte, input int unsigned bitpos);
    return sbyte[bitpos[2:0]];
  endfunction

  // A read may proceed unless it targets the bank that is programming.
  function automatic logic read_allowed(input logic req, input logic prog_on,
                                        input logic same_bank);
    return req && !(prog_on && same_bank);
  endfunction

endpackage

// File: rtl/rww_prog_tracker.sv
module rww_prog_tracker #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_start,
  input  logic [BANK_W-1:0] prog_bank,
  input  logic              poll_clear,
  output logic              prog_valid,
  output logic [BANK_W-1:0] prog_idx
);

  logic accept_start;
  assign accept_start = prog_start && !prog_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_valid <= 1'b0;
      prog_idx   <= '0;
    end else if (accept_start) begin
      prog_valid <= 1'b1;
      prog_idx   <= prog_bank;
    end else if (poll_clear) begin
      prog_valid <= 1'b0;
    end
  end

  // R2: a start pulse during programming leaves the stored bank alone
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid && prog_start && !poll_clear) |=> (prog_valid && $stable(prog_idx)));

  // R4: a not-busy status ends programming on the next clock
  a_r4_clear_ends_prog: assert property (@(posedge clk) disable iff (!rst_n)
    poll_clear |=> !prog_valid);

endmodule

// File: rtl/rww_bank_decode.sv
module rww_bank_decode #(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_en,
  input  logic [BANK_W-1:0]    sel_idx,
  output logic [NUM_BANKS-1:0] bank_sel
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_sel
    assign bank_sel[g] = sel_en && (sel_idx == BANK_W'(g));
  end

  // R9: never more than one bank selected
  a_r9_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel));

endmodule

// File: rtl/rww_sched.sv
module rww_sched
  import rww_pkg::*;
#(
  parameter int          NUM_BANKS = 4,
  parameter logic [7:0]  POLL_OP   = 8'h05,
  parameter logic [7:0]  READ_OP   = 8'h03,
  parameter int unsigned BUSY_BIT  = 0,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] rd_bank,
  output logic              rd_ready,
  input  logic              prog_valid,
  input  logic [BANK_W-1:0] prog_idx,
  output logic              poll_clear,
  output logic              cmd_valid,
  output logic [7:0]        cmd_opcode,
  input  logic              cmd_ready,
  input  logic              xfer_done,
  input  logic [7:0]        xfer_rx,
  output logic              sel_en,
  output logic [BANK_W-1:0] sel_idx
);

  rww_state_e        state, state_nx;
  logic [BANK_W-1:0] rd_bank_q;
  logic              xfer_open;

  // Named events
  logic read_ok;
  logic read_preempt;
  logic cmd_accept;
  logic poll_done;

  assign read_ok    = read_allowed(rd_req, prog_valid, rd_bank == prog_idx);
  assign cmd_accept = cmd_valid && cmd_ready;
  assign poll_done  = (state == ST_POLL_WAIT) && xfer_done;
  assign poll_clear = poll_done && !status_busy(xfer_rx, BUSY_BIT);
  assign read_preempt = (state == ST_POLL_GAP) && read_ok && prog_valid;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE, ST_POLL_GAP: begin
        if (read_ok)         state_nx = ST_RD_ISSUE;
        else if (prog_valid) state_nx = ST_POLL_ISSUE;
        else                 state_nx = ST_IDLE;
      end
      ST_POLL_ISSUE: if (cmd_ready) state_nx = ST_POLL_WAIT;
      ST_POLL_WAIT:  if (xfer_done) state_nx = ST_POLL_GAP;
      ST_RD_ISSUE:   if (cmd_ready) state_nx = ST_RD_WAIT;
      ST_RD_WAIT:    if (xfer_done) state_nx = ST_RD_ACK;
      ST_RD_ACK:     state_nx = prog_valid ? ST_POLL_ISSUE : ST_IDLE;
      default:       state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rd_bank_q <= '0;
    end else begin
      state <= state_nx;
      if (state_nx == ST_RD_ISSUE && state != ST_RD_ISSUE) rd_bank_q <= rd_bank;
    end
  end

  // Tracks an accepted transaction that has not yet completed.
  always_ff @(posedge clk) begin
    if (!rst_n)          xfer_open <= 1'b0;
    else if (cmd_accept) xfer_open <= 1'b1;
    else if (xfer_done)  xfer_open <= 1'b0;
  end

  always_comb begin
    cmd_valid  = 1'b0;
    cmd_opcode = 8'h00;
    sel_en     = 1'b0;
    sel_idx    = prog_idx;
    rd_ready   = 1'b0;
    unique case (state)
      ST_POLL_ISSUE: begin cmd_valid = 1'b1; cmd_opcode = POLL_OP; sel_en = 1'b1; end
      ST_POLL_WAIT:  sel_en = 1'b1;
      ST_RD_ISSUE:   begin cmd_valid = 1'b1; cmd_opcode = READ_OP; sel_en = 1'b1; sel_idx = rd_bank_q; end
      ST_RD_WAIT:    begin sel_en = 1'b1; sel_idx = rd_bank_q; end
      ST_RD_ACK:     rd_ready = 1'b1;
      default: ;
    endcase
  end

  // R8: no command while a transaction is open
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !xfer_open);

  // R7: deselect follows every completed transaction
  a_r7_deselect_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_open) |=> !sel_en);

  // R5: the programming bank is never answered while still busy
  a_r5_stall_busy_bank: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> !(prog_valid && rd_bank_q == prog_idx));

  // R3: status reads go only to the programming bank
  a_r3_poll_target: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_opcode == POLL_OP) |-> (prog_valid && sel_en && sel_idx == prog_idx));

  // R6: a preempting read is issued next, then polling resumes
  a_r6_preempt_issue: assert property (@(posedge clk) disable iff (!rst_n)
    read_preempt |=> (cmd_valid && cmd_opcode == READ_OP));

endmodule

// File: rtl/flash_rww_arbiter.sv
module flash_rww_arbiter #(
  parameter int          NUM_BANKS = 4,
  parameter logic [7:0]  POLL_OP   = 8'h05,
  parameter logic [7:0]  READ_OP   = 8'h03,
  parameter int unsigned BUSY_BIT  = 0,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_start,
  input  logic [BANK_W-1:0]    prog_bank,
  input  logic                 rd_req,
  input  logic [BANK_W-1:0]    rd_bank,
  output logic                 rd_ready,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic                 cmd_valid,
  output logic [7:0]           cmd_opcode,
  input  logic                 cmd_ready,
  input  logic                 xfer_done,
  input  logic [7:0]           xfer_rx,
  output logic                 prog_busy,
  output logic [BANK_W-1:0]    prog_idx
);

  logic              poll_clear;
  logic              prog_valid;
  logic              sel_en;
  logic [BANK_W-1:0] sel_idx;

  rww_prog_tracker #(.NUM_BANKS(NUM_BANKS)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_start (prog_start),
    .prog_bank  (prog_bank),
    .poll_clear (poll_clear),
    .prog_valid (prog_valid),
    .prog_idx   (prog_idx)
  );

  rww_sched #(
    .NUM_BANKS (NUM_BANKS),
    .POLL_OP   (POLL_OP),
    .READ_OP   (READ_OP),
    .BUSY_BIT  (BUSY_BIT)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rd_bank    (rd_bank),
    .rd_ready   (rd_ready),
    .prog_valid (prog_valid),
    .prog_idx   (prog_idx),
    .poll_clear (poll_clear),
    .cmd_valid  (cmd_valid),
    .cmd_opcode (cmd_opcode),
    .cmd_ready  (cmd_ready),
    .xfer_done  (xfer_done),
    .xfer_rx    (xfer_rx),
    .sel_en     (sel_en),
    .sel_idx    (sel_idx)
  );

  rww_bank_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_en   (sel_en),
    .sel_idx  (sel_idx),
    .bank_sel (bank_sel)
  );

  assign prog_busy = prog_valid;

  // R1: a read completes in a single-cycle acknowledge
  a_r1_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);

endmodule

// File: tb/flash_rww_arbiter_bench.sv
module flash_rww_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BW = 2;
  localparam int XFER_LEN = 3;     // cycles a transaction stays open
  localparam int LOG_MAX = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prog_start = 1'b0;
  logic [BW-1:0] prog_bank = '0;
  logic          rd_req = 1'b0;
  logic [BW-1:0] rd_bank = '0;
  logic          rd_ready;
  logic [NB-1:0] bank_sel;
  logic          cmd_valid;
  logic [7:0]    cmd_opcode;
  logic          cmd_ready = 1'b1;
  logic          xfer_done;
  logic [7:0]    xfer_rx;
  logic          prog_busy;
  logic [BW-1:0] prog_idx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rww_arbiter u_flash_rww_arbiter (
    .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_bank(prog_bank),
    .rd_req(rd_req), .rd_bank(rd_bank), .rd_ready(rd_ready), .bank_sel(bank_sel),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_ready(cmd_ready),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx), .prog_busy(prog_busy), .prog_idx(prog_idx)
  );

  // ---------------- shifter model ----------------
  int cnt = 0;
  int polls_seen = 0;
  int busy_base = 0;     // written by tests only
  int busy_target = 0;   // polls that still report busy
  logic [7:0] rx_q = 8'h00;

  assign xfer_done = (cnt == 1);
  assign xfer_rx   = rx_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= 0;
    end else if (cmd_valid && cmd_ready) begin
      cnt <= XFER_LEN;
      if (cmd_opcode == 8'h05) begin
        // busy bytes have bit0 set, done bytes carry noise in bits 7:1
        rx_q <= ((polls_seen - busy_base) < busy_target) ? 8'h01 : 8'hFE;
        polls_seen <= polls_seen + 1;
      end else begin
        rx_q <= 8'hA5;
      end
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
    end
  end

  // ---------------- monitor ----------------
  logic [7:0]    log_op [LOG_MAX];
  logic [NB-1:0] log_sel[LOG_MAX];
  int log_n = 0;
  bit need_gap = 0;
  int gap_viol = 0;
  int overlap_viol = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bank_sel == '0) need_gap = 0;
      if (cmd_valid && cmd_ready) begin
        if (need_gap) gap_viol++;
        if (cnt > 0) overlap_viol++;
        if (log_n < LOG_MAX) begin
          log_op[log_n]  = cmd_opcode;
          log_sel[log_n] = bank_sel;
        end
        log_n++;
      end
      if (xfer_done) need_gap = 1;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [NB-1:0] onehot(input int idx);
    return NB'(1) << idx;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_read(input int bank, output int lat, output bit busy_at_ready);
    @(negedge clk);
    rd_req = 1'b1; rd_bank = BW'(bank);
    lat = 0;
    busy_at_ready = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      lat++;
      if (rd_ready) begin
        busy_at_ready = prog_busy;
        break;
      end
    end
    rd_req = 1'b0;
  endtask

  task automatic start_prog(input int bank, input int nbusy);
    busy_base = polls_seen;
    busy_target = nbusy;
    @(negedge clk);
    prog_start = 1'b1; prog_bank = BW'(bank);
    @(negedge clk);
    prog_start = 1'b0;
  endtask

  task automatic wait_prog_end();
    for (int i = 0; i < 2000; i++) begin
      if (!prog_busy) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(bank_sel == '0, "R10 bank_sel", int'(bank_sel), 0);
    check(!cmd_valid, "R10 cmd_valid", int'(cmd_valid), 0);
    check(!rd_ready, "R10 rd_ready", int'(rd_ready), 0);
    check(!prog_busy, "R10 prog_busy", int'(prog_busy), 0);
  endtask

  task automatic t_idle_read();
    int base = log_n;
    int lat; bit b;
    do_read(2, lat, b);
    check(lat == XFER_LEN + 2, "R1 idle latency", lat, XFER_LEN + 2);
    @(negedge clk);
    check(!rd_ready, "R1 ready one cycle", int'(rd_ready), 0);
    check(log_n - base == 1, "R1 command count", log_n - base, 1);
    check(log_op[base] == 8'h03, "R1 read opcode", int'(log_op[base]), 3);
    check(log_sel[base] == onehot(2), "R1 read select", int'(log_sel[base]), int'(onehot(2)));
  endtask

  task automatic t_prog_plain();
    int base = log_n;
    bit all_ok = 1;
    start_prog(1, 3);
    check(prog_busy && prog_idx == 2'd1, "R2 start loads", int'(prog_idx), 1);
    wait_prog_end();
    // bit0 decides: 3 busy polls then one with 8'hFE
    check(log_n - base == 4, "R4 poll count", log_n - base, 4);
    for (int i = base; i < log_n; i++)
      if (log_op[i] != 8'h05 || log_sel[i] != onehot(1)) all_ok = 0;
    check(all_ok, "R3 polls to programming bank", int'(all_ok), 1);
    check(!prog_busy && bank_sel == '0 && !cmd_valid, "R4 quiet after done",
          int'(bank_sel), 0);
  endtask

  task automatic t_start_ignored();
    int base = log_n;
    bit all_ok = 1;
    start_prog(3, 5);
    repeat (3) @(negedge clk);
    prog_start = 1'b1; prog_bank = 2'd0;
    @(negedge clk);
    prog_start = 1'b0;
    @(negedge clk);
    check(prog_idx == 2'd3 && prog_busy, "R2 second start ignored", int'(prog_idx), 3);
    wait_prog_end();
    for (int i = base; i < log_n; i++)
      if (log_sel[i] != onehot(3)) all_ok = 0;
    check(all_ok && (log_n - base == 6), "R2 polls stay on bank 3", log_n - base, 6);
  endtask

  task automatic t_read_same_bank();
    int base = log_n;
    int lat; bit b;
    bit polls_ok = 1;
    start_prog(2, 4);
    repeat (3) @(negedge clk);
    do_read(2, lat, b);
    check(!b, "R5 ready only after programming", int'(b), 0);
    check(log_n - base == 6, "R5 command count", log_n - base, 6);
    for (int i = base; i < base + 5; i++)
      if (log_op[i] != 8'h05) polls_ok = 0;
    check(polls_ok, "R5 polls precede read", int'(polls_ok), 1);
    check(log_op[base+5] == 8'h03 && log_sel[base+5] == onehot(2), "R5 read served last",
          int'(log_op[base+5]), 3);
    wait_prog_end();
  endtask

  task automatic t_read_other_bank();
    int base = log_n;
    int lat; bit b;
    int k = -1;
    start_prog(1, 6);
    repeat (4) @(negedge clk);
    do_read(3, lat, b);
    check(b, "R6 read served during programming", int'(b), 1);
    wait_prog_end();
    check(log_n - base == 8, "R6 command count", log_n - base, 8);
    for (int i = base; i < log_n; i++)
      if (log_op[i] == 8'h03) k = i;
    check(k > base && k < log_n - 1, "R6 read between polls", k - base, 1);
    if (k > base && k < log_n - 1) begin
      check(log_sel[k] == onehot(3), "R6 read select", int'(log_sel[k]), int'(onehot(3)));
      check(log_op[k-1] == 8'h05, "R6 poll before read", int'(log_op[k-1]), 5);
      check(log_op[k+1] == 8'h05 && log_sel[k+1] == onehot(1), "R6 poll resumes",
            int'(log_sel[k+1]), int'(onehot(1)));
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_read();
    t_prog_plain();
    t_start_ignored();
    t_read_same_bank();
    t_read_other_bank();
    check(gap_viol == 0, "R7 deselect gaps", gap_viol, 0);
    check(overlap_viol == 0, "R8 no overlap", overlap_viol, 0);
    check(log_n <= LOG_MAX, "R9 log fits", log_n, LOG_MAX);
    finish_run();
  end

endmodule